// File: doc/BRIEF.md
# Single-Message Record and Playback Sequencer

This controller runs one voice message held in an external sample memory. Three level inputs steer it: a power-down request, a play/record selector and an active-low run enable. A fourth input, an active-low trigger, starts a playback on its own. A sample-period divider paces the work. On each sample period the block either takes one input sample or presents one stored sample, and then moves its address pointer forward by one.

Recorded samples are gathered into groups. Each group goes to memory in a single wide write, because one storage write lasts longer than a sample period. When a recording is stopped, the block writes any partly filled group and then sets a per-address end marker at the stop point. Playback halts on that marker and gives a timed low pulse on the active-low end-of-message output. If the pointer runs to the end of memory, the output stays low instead until power-down. The trigger sets a latch that holds the block running in playback until the end of the message, so a brief press plays the whole message.

All four control inputs come in asynchronously. Each one passes through a two-flop synchroniser and a debounce counter before the controller uses it.

Top module: `msg_seq`

## Requirements
- R1: While power-down is in effect (idle_o high), the pointer ptr_o is 0, no memory write or marker write occurs and no sample strobe is issued. Once power-down is in effect again after any run, ptr_o reads 0.
- R2: A run starts when effective power-down is low and effective enable is low. It records if the mode input is 0 and plays back if it is 1. The mode is sampled only at that start, and a later mode change has no effect until the next power-down.
- R3: During a run, one sample strobe comes every TICK_DIV clock cycles and each strobe moves ptr_o up by exactly 1. Releasing enable ends the run, and the block then waits with eom_n_o high until power-down.
- R4: Recorded samples are written GROUP at a time. A full group is one mem_we_o cycle with a group-aligned base address (low log2(GROUP) bits zero) and all mask bits set. Lane k carries the sample for address base+k at bits [k*SW +: SW]. A group write clears the end markers of the addresses it writes.
- R5: When a recording ends by releasing enable or by raising power-down, the next cycle writes the partial group with mask bits 0..n-1 set, where n = ptr mod GROUP. In the same cycle a marker is set at the address equal to the number of samples taken.
- R6: In playback, when the marker is read at the pointer, no sample is output. eom_n_o goes low for exactly EOM_CYC cycles, and the block then stops.
- R7: When the pointer reaches DEPTH in either mode, eom_n_o goes low and stays low until power-down, and no marker is written.
- R8: A falling edge of the debounced trigger while idle sets a latch. The latch forces power-down and enable low and selects playback, whatever the raw inputs are. It clears at the end of the marker pulse or on reaching full memory, and after that the raw inputs govern again.
- R9: A control input change lasting fewer than DEB cycles has no effect.
- R10: Each played sample appears on smp_o with smp_vld_o high for one cycle, the cycle after its strobe, and equals the sample stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_raw_i | input | 1 | Asynchronous power-down request, high = power down |
| mode_raw_i | input | 1 | Asynchronous mode select, 1 = playback, 0 = record |
| ce_n_raw_i | input | 1 | Asynchronous active-low run enable |
| trig_n_raw_i | input | 1 | Asynchronous active-low playback trigger |
| smp_i | input | SW | Sample to record |
| smp_stb_o | output | 1 | Sample strobe: a sample is taken or presented this cycle |
| smp_o | output | SW | Played-back sample |
| smp_vld_o | output | 1 | smp_o valid |
| eom_n_o | output | 1 | Active-low end of message |
| idle_o | output | 1 | Block is in the powered-down state |
| ptr_o | output | log2(DEPTH)+1 | Address pointer |
| mem_we_o | output | 1 | Group write strobe |
| mem_wbase_o | output | log2(DEPTH) | Group base address |
| mem_wdata_o | output | GROUP*SW | Group write data |
| mem_wmask_o | output | GROUP | Lane write mask |
| mem_mk_we_o | output | 1 | Marker set strobe |
| mem_mk_addr_o | output | log2(DEPTH) | Marker address |
| mem_raddr_o | output | log2(DEPTH) | Read address |
| mem_rdata_i | input | SW | Stored sample at mem_raddr_o |
| mem_rmark_i | input | 1 | Marker bit at mem_raddr_o |

## Verification
Two situations are the hardest to reach from the ports. The first is a message that overwrites a longer one, where the stale markers must not cut playback short. The second is a stop that lands in the middle of a group. The debounce delay means the bench cannot choose the stop sample exactly. Instead it logs every strobe it sees and drives a new random length each time. It first fills the whole memory, then makes several shorter recordings, and checks each marker position and each playback against its own log.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_REC, ST_WRAP, ST_PLAY, ST_EOMP, ST_HALT, ST_FULL
  } seq_st_e;

  // a run stops when either power-down is requested or enable is released
  function automatic logic run_ends(input logic pd, input logic ce_n);
    return pd | ce_n;
  endfunction
endpackage

// File: rtl/msq_deb.sv
module msq_deb #(
  parameter int   DEB  = 4,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;
  logic s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q    <= INIT;
      s2_q    <= INIT;
      clean_o <= INIT;
      cnt_q   <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != clean_o) begin
        if (cnt_q == CW'(DEB - 1)) begin
          clean_o <= s2_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/msq_tick.sv
module msq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/msq_grpbuf.sv
module msq_grpbuf #(
  parameter int SW    = 8,
  parameter int GROUP = 4,
  localparam int LG   = $clog2(GROUP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_i,
  input  logic [LG-1:0]         sel_i,
  input  logic [SW-1:0]         din_i,
  input  logic                  byp_i,
  output logic [GROUP*SW-1:0]   wdata_o
);
  for (genvar gi = 0; gi < GROUP; gi++) begin : g_lane
    logic [SW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             lane_q <= '0;
      else if (ld_i && sel_i == LG'(gi))      lane_q <= din_i;
    end
    if (gi == GROUP - 1) begin : g_last
      // the closing lane is sent straight through on a group commit
      assign wdata_o[gi*SW +: SW] = byp_i ? din_i : lane_q;
    end else begin : g_mid
      assign wdata_o[gi*SW +: SW] = lane_q;
    end
  end
endmodule

// File: rtl/msg_seq.sv
module msg_seq
  import msq_pkg::*;
#(
  parameter int SW       = 8,
  parameter int DEPTH    = 64,
  parameter int GROUP    = 4,
  parameter int TICK_DIV = 4,
  parameter int EOM_CYC  = 20,
  parameter int DEB      = 4,
  localparam int AM      = $clog2(DEPTH),
  localparam int AW      = AM + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_raw_i,
  input  logic                mode_raw_i,
  input  logic                ce_n_raw_i,
  input  logic                trig_n_raw_i,
  input  logic [SW-1:0]       smp_i,
  output logic                smp_stb_o,
  output logic [SW-1:0]       smp_o,
  output logic                smp_vld_o,
  output logic                eom_n_o,
  output logic                idle_o,
  output logic [AW-1:0]       ptr_o,
  output logic                mem_we_o,
  output logic [AM-1:0]       mem_wbase_o,
  output logic [GROUP*SW-1:0] mem_wdata_o,
  output logic [GROUP-1:0]    mem_wmask_o,
  output logic                mem_mk_we_o,
  output logic [AM-1:0]       mem_mk_addr_o,
  output logic [AM-1:0]       mem_raddr_o,
  input  logic [SW-1:0]       mem_rdata_i,
  input  logic                mem_rmark_i
);
  localparam int LG = $clog2(GROUP);
  localparam int EW = $clog2(EOM_CYC + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [3:0]    DEB_INIT = 4'b1111;

  // lanes below n are valid in a partial group
  function automatic logic [GROUP-1:0] low_lanes(input logic [LG-1:0] n);
    logic [GROUP-1:0] m;
    for (int i = 0; i < GROUP; i++) m[i] = (LG'(i) < n);
    return m;
  endfunction

  // ---------------- input conditioning ----------------
  logic [3:0] raw_v, deb_v;
  assign raw_v = {trig_n_raw_i, ce_n_raw_i, mode_raw_i, pd_raw_i};
  for (genvar gi = 0; gi < 4; gi++) begin : g_in
    msq_deb #(.DEB(DEB), .INIT(DEB_INIT[gi])) u_deb (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_v[gi]), .clean_o(deb_v[gi])
    );
  end

  seq_st_e state_q, state_d;
  logic [AW-1:0] ptr_q;
  logic [EW-1:0] ecnt_q;
  logic latch_q, trig_prev_q;

  // effective controls after the playback latch
  logic pd_eff, ce_eff_n, mode_eff, run_stop, trig_fall;
  assign pd_eff    = deb_v[0] & ~latch_q;
  assign mode_eff  = deb_v[1] | latch_q;
  assign ce_eff_n  = deb_v[2] & ~latch_q;
  assign run_stop  = run_ends(pd_eff, ce_eff_n);
  assign trig_fall = trig_prev_q & ~deb_v[3];

  // ---------------- sample period ----------------
  logic tick, run_en;
  assign run_en = (state_q == ST_REC) || (state_q == ST_PLAY);
  msq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(run_en), .tick_o(tick)
  );

  // ---------------- named events ----------------
  logic [LG-1:0] lane;
  logic ev_rec_tick, ev_play_tick, ev_mark_hit, ev_play_smp;
  logic ev_commit, ev_flush, ev_rec_stop, ev_latch_clr, st_full, ev_pulse_end;
  assign lane         = ptr_q[LG-1:0];
  assign ev_rec_tick  = (state_q == ST_REC)  && !run_stop && tick;
  assign ev_play_tick = (state_q == ST_PLAY) && !run_stop && tick;
  assign ev_mark_hit  = ev_play_tick && mem_rmark_i;
  assign ev_play_smp  = ev_play_tick && !mem_rmark_i;
  assign ev_commit    = ev_rec_tick && (lane == LG'(GROUP - 1));
  assign ev_flush     = (state_q == ST_WRAP) && (lane != '0);
  assign ev_rec_stop  = (state_q == ST_REC) && run_stop;
  assign st_full      = (state_q == ST_FULL);
  assign ev_pulse_end = (state_q == ST_EOMP) && (ecnt_q == EW'(EOM_CYC - 1));
  assign ev_latch_clr = (ev_pulse_end && !pd_eff) || st_full;

  // ---------------- sequencing ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (!pd_eff && !ce_eff_n) state_d = mode_eff ? ST_PLAY : ST_REC;
      ST_REC: begin
        if (run_stop)                               state_d = ST_WRAP;
        else if (tick && ptr_q == LAST_PTR)         state_d = ST_FULL;
      end
      ST_WRAP: state_d = pd_eff ? ST_OFF : ST_HALT;
      ST_PLAY: begin
        if (run_stop)                               state_d = pd_eff ? ST_OFF : ST_HALT;
        else if (ev_mark_hit)                       state_d = ST_EOMP;
        else if (tick && ptr_q == LAST_PTR)         state_d = ST_FULL;
      end
      ST_EOMP: begin
        if (pd_eff)                                 state_d = ST_OFF;
        else if (ev_pulse_end)                      state_d = ST_HALT;
      end
      ST_HALT: if (pd_eff) state_d = ST_OFF;
      ST_FULL: if (pd_eff) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_OFF;
      ptr_q       <= '0;
      ecnt_q      <= '0;
      latch_q     <= 1'b0;
      trig_prev_q <= 1'b1;
      smp_o       <= '0;
      smp_vld_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      trig_prev_q <= deb_v[3];
      if (state_d == ST_OFF)  ptr_q <= '0;
      else if (smp_stb_o)     ptr_q <= ptr_q + 1'b1;
      ecnt_q <= (state_q == ST_EOMP) ? ecnt_q + 1'b1 : '0;
      if (state_q == ST_OFF && trig_fall) latch_q <= 1'b1;
      else if (ev_latch_clr)              latch_q <= 1'b0;
      smp_vld_o <= ev_play_smp;
      if (ev_play_smp) smp_o <= mem_rdata_i;
    end
  end

  // ---------------- write grouping ----------------
  msq_grpbuf #(.SW(SW), .GROUP(GROUP)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_i(ev_rec_tick), .sel_i(lane),
    .din_i(smp_i), .byp_i(ev_commit), .wdata_o(mem_wdata_o)
  );

  assign mem_we_o      = ev_commit | ev_flush;
  assign mem_wmask_o   = ev_commit ? '1 : low_lanes(lane);
  assign mem_wbase_o   = {ptr_q[AM-1:LG], LG'(0)};
  assign mem_mk_we_o   = (state_q == ST_WRAP);
  assign mem_mk_addr_o = ptr_q[AM-1:0];
  assign mem_raddr_o   = ptr_q[AM-1:0];

  assign smp_stb_o = ev_rec_tick | ev_play_smp;
  assign eom_n_o   = !((state_q == ST_EOMP) || st_full);
  assign idle_o    = (state_q == ST_OFF);
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/msg_seq_chk.sv
module msg_seq_chk #(
  parameter int AM      = 6,
  parameter int AW      = 7,
  parameter int LG      = 2,
  parameter int EOM_CYC = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_o,
  input logic [AW-1:0] ptr_o,
  input logic          mem_we_o,
  input logic          mem_mk_we_o,
  input logic [AM-1:0] mem_wbase_o,
  input logic          smp_stb_o,
  input logic          eom_n_o,
  input logic          st_full,
  input logic          pd_eff,
  input logic          ev_rec_stop,
  input logic          latch_q
);
  logic [15:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      low_run_q <= '0;
    else if (!eom_n_o && !st_full)   low_run_q <= low_run_q + 1'b1;
    else                             low_run_q <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (ptr_o == '0 && !mem_we_o && !mem_mk_we_o && !smp_stb_o));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb_o |=> ptr_o == $past(ptr_o) + 1'b1);

  a_r4_group_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_wbase_o[LG-1:0] == '0);

  a_r5_marker_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rec_stop |=> mem_mk_we_o);

  a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!eom_n_o && !st_full) |-> low_run_q < 16'(EOM_CYC));

  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && !pd_eff) |=> !eom_n_o);

  a_r8_latch_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q |-> (!mem_we_o && !mem_mk_we_o));
endmodule

bind msg_seq msg_seq_chk #(.AM(AM), .AW(AW), .LG(LG), .EOM_CYC(EOM_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_o(idle_o), .ptr_o(ptr_o),
  .mem_we_o(mem_we_o), .mem_mk_we_o(mem_mk_we_o), .mem_wbase_o(mem_wbase_o),
  .smp_stb_o(smp_stb_o), .eom_n_o(eom_n_o), .st_full(st_full),
  .pd_eff(pd_eff), .ev_rec_stop(ev_rec_stop), .latch_q(latch_q)
);

// File: tb/msg_seq_tb.sv
module msg_seq_tb;
  localparam int SW = 8, DEPTH = 64, GROUP = 4, TICK_DIV = 4, EOM_CYC = 20, DEB = 4;
  localparam int AM = $clog2(DEPTH), AW = AM + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd = 1'b1, mode = 1'b1, ce_n = 1'b1, trig_n = 1'b1;
  logic [SW-1:0] smp = '0;
  logic smp_stb, smp_vld, eom_n, idle, mem_we, mem_mk_we, mem_rmark;
  logic [SW-1:0] smp_out, mem_rdata;
  logic [AW-1:0] ptr;
  logic [AM-1:0] mem_wbase, mem_mk_addr, mem_raddr;
  logic [GROUP*SW-1:0] mem_wdata;
  logic [GROUP-1:0] mem_wmask;

  always #10 clk = ~clk;

  msg_seq #(.SW(SW), .DEPTH(DEPTH), .GROUP(GROUP), .TICK_DIV(TICK_DIV),
            .EOM_CYC(EOM_CYC), .DEB(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_raw_i(pd), .mode_raw_i(mode), .ce_n_raw_i(ce_n),
    .trig_n_raw_i(trig_n), .smp_i(smp), .smp_stb_o(smp_stb), .smp_o(smp_out),
    .smp_vld_o(smp_vld), .eom_n_o(eom_n), .idle_o(idle), .ptr_o(ptr),
    .mem_we_o(mem_we), .mem_wbase_o(mem_wbase), .mem_wdata_o(mem_wdata),
    .mem_wmask_o(mem_wmask), .mem_mk_we_o(mem_mk_we), .mem_mk_addr_o(mem_mk_addr),
    .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata), .mem_rmark_i(mem_rmark)
  );

  // memory model following R4/R5: lanes write and clear markers, marker strobe sets one
  logic [SW-1:0] mem [DEPTH];
  logic          mk  [DEPTH];
  assign mem_rdata = mem[mem_raddr];
  assign mem_rmark = mk[mem_raddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin mem[i] <= '0; mk[i] <= 1'b0; end
    end else begin
      if (mem_we)
        for (int l = 0; l < GROUP; l++)
          if (mem_wmask[l]) begin
            mem[int'(mem_wbase) + l] <= mem_wdata[l*SW +: SW];
            mk[int'(mem_wbase) + l]  <= 1'b0;
          end
      if (mem_mk_we) mk[mem_mk_addr] <= 1'b1;
    end
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: logs recorded samples, compares played ones, counts events
  logic [SW-1:0] exp_q [DEPTH];
  int ne = 0, np = 0, lowcnt = 0, wecnt = 0, mkcnt = 0, idle_bad = 0, stbcnt = 0;
  bit rec_on = 0, play_on = 0;
  always @(negedge clk) begin
    if (rec_on && smp_stb) begin
      if (ne < DEPTH) exp_q[ne] = smp;
      ne++;
    end else smp = SW'($urandom);
    if (smp_vld) begin
      if (play_on && np < DEPTH)
        chk(smp_out == exp_q[np], "R10 played sample", int'(smp_out), int'(exp_q[np]));
      np++;
    end
    if (!eom_n) lowcnt++;
    if (mem_we) wecnt++;
    if (mem_mk_we) mkcnt++;
    if (smp_stb) stbcnt++;
    if (rst_n && idle && (mem_we || mem_mk_we || smp_stb)) idle_bad++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    pd = 1'b1; ce_n = 1'b1; cyc(20);
    chk(idle && ptr == '0, "R1 idle after power-down", int'(ptr), 0);
  endtask

  task automatic mem_chk(input int n, input bit marked);
    int bad = 0;
    for (int i = 0; i < n && i < DEPTH; i++) if (mem[i] !== exp_q[i]) bad++;
    chk(bad == 0, "R4 stored samples", bad, 0);
    if (marked && n < DEPTH) begin
      chk(mk[n] == 1'b1, "R5 marker at stop address", int'(mk[n]), 1);
      bad = 0;
      for (int i = 0; i < n; i++) if (mk[i]) bad++;
      chk(bad == 0, "R4 old markers cleared", bad, 0);
    end
  endtask

  task automatic record(input int n, input bit by_pd);
    ne = 0; rec_on = 1; mode = 1'b0; pd = 1'b0; ce_n = 1'b0;
    for (int t = 0; t < 4000 && ne < n; t++) cyc(1);
    if (by_pd) pd = 1'b1; else ce_n = 1'b1;
    cyc(20);
    rec_on = 0;
    chk(eom_n, "R3 stop leaves eom high", int'(eom_n), 1);
    mem_chk(ne, 1);
    go_idle();
    mode = 1'b1;
  endtask

  task automatic wait_pulse();
    for (int t = 0; t < 4000 && eom_n; t++) cyc(1);
    for (int t = 0; t < 4000 && !eom_n; t++) cyc(1);
  endtask

  task automatic play(input bit chg_mode);
    np = 0; lowcnt = 0; wecnt = 0; play_on = 1;
    mode = 1'b1; pd = 1'b0; ce_n = 1'b0;
    for (int t = 0; t < 4000 && eom_n; t++) begin
      cyc(1);
      if (chg_mode && np == 2) mode = 1'b0;
    end
    for (int t = 0; t < 4000 && !eom_n; t++) cyc(1);
    chk(lowcnt == EOM_CYC, "R6 marker pulse width", lowcnt, EOM_CYC);
    chk(np == ne, "R6 samples before marker", np, ne);
    cyc(10);
    chk(np == ne && !idle && eom_n, "R3 halted after pulse", np, ne);
    chk(wecnt == 0, "R2 playback never writes", wecnt, 0);
    play_on = 0;
    go_idle();
    mode = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cyc(5); rst_n = 1'b1; cyc(2);
    chk(idle && eom_n && ptr == '0 && !smp_vld, "R1 reset state", int'(ptr), 0);

    // R9: short enable glitch with power-down released
    pd = 1'b0; cyc(20);
    stbcnt = 0;
    ce_n = 1'b0; cyc(2); ce_n = 1'b1; cyc(20);
    chk(idle && stbcnt == 0, "R9 glitch ignored", stbcnt, 0);
    pd = 1'b1; cyc(20);

    // R7: fill the memory
    ne = 0; mkcnt = 0; rec_on = 1; mode = 1'b0; pd = 1'b0; ce_n = 1'b0;
    for (int t = 0; t < 4000 && eom_n; t++) cyc(1);
    chk(ne == DEPTH, "R7 full after DEPTH samples", ne, DEPTH);
    cyc(50);
    rec_on = 0;
    chk(!eom_n, "R7 eom held at full", int'(eom_n), 0);
    chk(mkcnt == 0, "R7 no marker at full", mkcnt, 0);
    mem_chk(DEPTH, 0);
    go_idle();
    chk(eom_n, "R7 eom released by power-down", int'(eom_n), 1);

    // R7: playback of a full memory
    np = 0; play_on = 1; mode = 1'b1; pd = 1'b0; ce_n = 1'b0;
    for (int t = 0; t < 4000 && eom_n; t++) cyc(1);
    cyc(50);
    chk(np == DEPTH && !eom_n, "R7 playback reaches full", np, DEPTH);
    play_on = 0;
    go_idle();

    // shorter messages over longer ones, random lengths, both stop ways
    for (int r = 0; r < 5; r++) begin
      record(1 + int'($urandom % 40), r[0]);
      play(r == 2);
    end

    // R8: trigger pulse with raw inputs asking for power-down and record
    pd = 1'b1; ce_n = 1'b1; mode = 1'b0; cyc(20);
    np = 0; lowcnt = 0; wecnt = 0; play_on = 1;
    trig_n = 1'b0; cyc(8); trig_n = 1'b1;
    wait_pulse();
    chk(np == ne, "R8 latched playback length", np, ne);
    chk(lowcnt == EOM_CYC, "R8 latched pulse width", lowcnt, EOM_CYC);
    chk(wecnt == 0, "R8 latched run did not record", wecnt, 0);
    cyc(10);
    chk(idle && ptr == '0, "R8 latch cleared to idle", int'(idle), 1);
    play_on = 0; mode = 1'b1;

    chk(idle_bad == 0, "R1 no activity while idle", idle_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule